// File: doc/BRIEF.md
# Narrow Read Byte-Lane Placement Unit

This block sits on the target side of a 64-bit AXI4 read path. It takes one read request at a time (start address, transfer size, burst type and beat count), walks the burst beat by beat, and places the word fetched from a combinational memory port onto the read data bus. Only the byte lanes that the current beat actually addresses carry memory data. All other lanes are driven to zero, so an initiator can rely on deterministic contents.

The lane set is worked out again for every beat from that beat's address and the transfer size. An unaligned start therefore yields a short first beat. That beat covers only the lanes from the start byte up to the next size boundary. Incrementing bursts then continue on size-aligned addresses. Fixed bursts repeat the start address and its lane set on every beat. The block raises the last-beat flag on the final beat. It accepts a new request only when no burst is in progress.

Top module: `rd_lane_placer`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of a burst, `r_valid` is low and `ar_ready` is high.
- R2: `ar_ready` is high only while no burst is active. A request presented during a burst is neither accepted nor allowed to disturb the data of the running burst.
- R3: The lanes of a beat run from lane `addr[2:0]` up to the last lane below the next size boundary. Size code 2 at 0x0 gives lanes 0–3 (mask 0x0F), at 0x4 gives lanes 4–7 (0xF0), and at 0x5 gives lanes 5–7 (0xE0). Lane i is `r_data[8i+7:8i]`.
- R4: Size code 3 (8 bytes) at an 8-byte-aligned address drives all eight lanes.
- R5: Every lane outside the active set reads as 8'h00. Every active lane carries the same byte of `mem_rdata`.
- R6: For burst code 1 (INCR), beat n ≥ 1 uses address `align(start, size) + n * 2^size`, so every beat after the first is size-aligned.
- R7: For burst code 0 (FIXED), every beat uses the start address and its lane set.
- R8: `r_last` is high exactly on beat number `ar_len` (counting from 0). After that beat's handshake, `r_valid` drops in the next cycle.
- R9: A beat advances only on a cycle where `r_valid` and `r_ready` are both high. While `r_ready` is low, the data, last flag and memory address hold.
- R10: `mem_addr` equals the current beat address rounded down to a multiple of 8.
- R11: Bytes per beat is 2^size. Size codes above 3 behave as size 3. Burst codes 2 and 3 step like INCR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted this cycle if valid |
| ar_addr | input | 32 | Start byte address |
| ar_size | input | 3 | Log2 of bytes per beat |
| ar_burst | input | 2 | Burst type code: 0 fixed, 1 incrementing |
| ar_len | input | 8 | Number of beats minus one |
| mem_addr | output | 32 | Word address presented to the memory port |
| mem_rdata | input | 64 | Word returned combinationally by the memory port |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat accepted when high with r_valid |
| r_data | output | 64 | Lane-placed read data |
| r_last | output | 1 | Marks the final beat of the burst |

## Verification
The request is registered at the handshake edge. The first beat's `r_valid`, `r_data`, `r_last` and `mem_addr` are therefore due one clock after the request is taken, and each later beat's outputs are due one clock after the previous beat's `r_valid`/`r_ready` handshake. Lane placement adds no register, so data follows `mem_rdata` in the same cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge after each rising edge that should change them. A stalled cycle is sampled twice to confirm that nothing moves. Once a burst's last handshake is done, a further falling-edge sample confirms that the bus is idle again.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'd0,
        BURST_INCR  = 2'd1,
        BURST_WRAP  = 2'd2,
        BURST_RSVD  = 2'd3
    } burst_e;

    // Limit a size code to the widest beat the bus can carry.
    function automatic logic [2:0] clamp_log(input logic [2:0] s, input logic [2:0] max_log);
        return (s > max_log) ? max_log : s;
    endfunction

endpackage

// File: rtl/rlp_lane_mask.sv
module rlp_lane_mask #(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [2:0]       size_i,
    output logic [LANES-1:0] mask_o
);
    logic [OFF_W:0] nbytes;
    logic [OFF_W:0] base;
    logic [OFF_W:0] hi;
    logic [OFF_W:0] lo;

    always_comb begin
        nbytes = (OFF_W+1)'(1) << size_i;
        lo     = {1'b0, off_i};
        base   = lo & ~(nbytes - (OFF_W+1)'(1));
        hi     = base + nbytes - (OFF_W+1)'(1);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_o[g] = (lo <= (OFF_W+1)'(g)) && ((OFF_W+1)'(g) <= hi);
    end

    always_comb begin
        AST_START_LANE_ON: assert (mask_o[off_i]) else $error("start lane not active"); // R3
        AST_MASK_WITHIN_SIZE: assert ($countones(mask_o) <= int'(nbytes)) else $error("too many lanes"); // R3
    end

endmodule

// File: rtl/rlp_data_gate.sv
module rlp_data_gate #(
    parameter int LANES = 8,
    localparam int DATA_W = LANES * 8
) (
    input  logic [LANES-1:0]  mask_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_gate
        assign data_o[g*8 +: 8] = mask_i[g] ? word_i[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/rlp_beat_ctrl.sv
module rlp_beat_ctrl
    import rlp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int LANES  = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid_i,
    output logic              ar_ready_o,
    input  logic [ADDR_W-1:0] ar_addr_i,
    input  logic [2:0]        ar_size_i,
    input  logic [1:0]        ar_burst_i,
    input  logic [LEN_W-1:0]  ar_len_i,
    input  logic              r_ready_i,
    output logic              r_valid_o,
    output logic              r_last_o,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [2:0]        beat_size_o
);
    typedef struct packed {
        logic              busy;
        logic              fixed;
        logic [2:0]        size;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  beat;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ADDR_W-1:0] step_d;
    logic [ADDR_W-1:0] aligned_d;
    logic              last_d;

    always_comb begin
        ctl_d     = ctl_q;
        step_d    = ADDR_W'(1) << ctl_q.size;
        aligned_d = ctl_q.addr & ~(step_d - ADDR_W'(1));
        last_d    = ctl_q.beat == ctl_q.len;
        if (!ctl_q.busy) begin
            if (ar_valid_i) begin
                ctl_d.busy  = 1'b1;
                ctl_d.fixed = burst_e'(ar_burst_i) == BURST_FIXED;
                ctl_d.size  = clamp_log(ar_size_i, 3'(OFF_W));
                ctl_d.len   = ar_len_i;
                ctl_d.beat  = '0;
                ctl_d.addr  = ar_addr_i;
            end
        end else if (r_ready_i) begin
            if (last_d) begin
                ctl_d.busy = 1'b0;
            end else begin
                ctl_d.beat = ctl_q.beat + LEN_W'(1);
                if (!ctl_q.fixed) begin
                    ctl_d.addr = aligned_d + step_d;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ar_ready_o  = !ctl_q.busy;
    assign r_valid_o   = ctl_q.busy;
    assign r_last_o    = ctl_q.busy && last_d;
    assign beat_addr_o = ctl_q.addr;
    assign beat_size_o = ctl_q.size;

    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid_i && ar_ready_o) |=> (r_valid_o && ctl_q.beat == '0)) else $error("accept"); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(ctl_q.addr) && $stable(ctl_q.beat))) else $error("stall"); // R9
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_o && r_ready_i && r_last_o) |=> !r_valid_o) else $error("last"); // R8
    AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_o && r_ready_i && !r_last_o && ctl_q.fixed) |=> $stable(ctl_q.addr)) else $error("fixed"); // R7
    AST_INCR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid_o && r_ready_i && !r_last_o && !ctl_q.fixed)
        |=> ((ctl_q.addr & ((ADDR_W'(1) << ctl_q.size) - ADDR_W'(1))) == '0)) else $error("incr"); // R6

endmodule

// File: rtl/rd_lane_placer.sv
module rd_lane_placer #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int LANES  = 8,
    localparam int DATA_W = LANES * 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [2:0]        ar_size,
    input  logic [1:0]        ar_burst,
    input  logic [LEN_W-1:0]  ar_len,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic              r_last
);
    logic [ADDR_W-1:0] beat_addr;
    logic [2:0]        beat_size;
    logic [LANES-1:0]  lane_mask;

    rlp_beat_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ar_valid_i  (ar_valid),
        .ar_ready_o  (ar_ready),
        .ar_addr_i   (ar_addr),
        .ar_size_i   (ar_size),
        .ar_burst_i  (ar_burst),
        .ar_len_i    (ar_len),
        .r_ready_i   (r_ready),
        .r_valid_o   (r_valid),
        .r_last_o    (r_last),
        .beat_addr_o (beat_addr),
        .beat_size_o (beat_size)
    );

    rlp_lane_mask #(.LANES(LANES)) mask_i (
        .off_i  (beat_addr[OFF_W-1:0]),
        .size_i (beat_size),
        .mask_o (lane_mask)
    );

    rlp_data_gate #(.LANES(LANES)) gate_i (
        .mask_i (lane_mask),
        .word_i (mem_rdata),
        .data_o (r_data)
    );

    assign mem_addr = {beat_addr[ADDR_W-1:OFF_W], OFF_W'(0)};

    AST_IDLE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !r_valid |-> !r_last) else $error("last while idle"); // R8

endmodule

// File: tb/rd_lane_placer_tb_top.sv
`timescale 1ns/1ps
module rd_lane_placer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ar_valid = 1'b0;
    logic        ar_ready;
    logic [31:0] ar_addr = '0;
    logic [2:0]  ar_size = '0;
    logic [1:0]  ar_burst = '0;
    logic [7:0]  ar_len = '0;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        r_valid;
    logic        r_ready = 1'b0;
    logic [63:0] r_data;
    logic        r_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rd_lane_placer dut_i (
        .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_size(ar_size), .ar_burst(ar_burst), .ar_len(ar_len),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .r_valid(r_valid), .r_ready(r_ready),
        .r_data(r_data), .r_last(r_last)
    );

    // Memory model: each byte holds the low 8 bits of its own byte address.
    always_comb begin
        for (int i = 0; i < 8; i++) mem_rdata[i*8 +: 8] = mem_addr[7:0] + 8'(i);
    end

    localparam int NV = 9;
    localparam logic [31:0] V_ADDR  [NV] = '{32'h0, 32'h4, 32'h5, 32'h7, 32'h0, 32'h103, 32'h21, 32'h13, 32'h6};
    localparam logic [2:0]  V_SIZE  [NV] = '{3'd2, 3'd2, 3'd2, 3'd2, 3'd3, 3'd1, 3'd0, 3'd5, 3'd2};
    localparam logic [1:0]  V_BURST [NV] = '{2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd1, 2'd3};
    localparam logic [7:0]  V_LEN   [NV] = '{8'd0, 8'd0, 8'd2, 8'd1, 8'd1, 8'd3, 8'd2, 8'd1, 8'd0};
    localparam logic [7:0]  V_MASK0 [NV] = '{8'h0F, 8'hF0, 8'hE0, 8'h80, 8'hFF, 8'h08, 8'h02, 8'hF8, 8'hC0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mask(input logic [31:0] a, input logic [2:0] s);
        int lg = (s > 3'd3) ? 3 : int'(s);
        int nb = 1 << lg;
        int off = int'(a[2:0]);
        int base = off - (off % nb);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (i >= off) && (i < base + nb);
        return m;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [2:0] s,
                                             input logic [1:0] b, input int n);
        int lg = (s > 3'd3) ? 3 : int'(s);
        logic [31:0] nb = 32'd1 << lg;
        if (n == 0 || b == 2'd0) return a;
        return (a & ~(nb - 32'd1)) + nb * 32'(n);
    endfunction

    function automatic logic [63:0] exp_data(input logic [31:0] a, input logic [7:0] m);
        logic [63:0] d;
        logic [7:0] wb = {a[7:3], 3'b000};
        for (int i = 0; i < 8; i++) d[i*8 +: 8] = m[i] ? wb + 8'(i) : 8'h00;
        return d;
    endfunction

    // Issue one request, then walk every beat; optionally stall beat 1.
    task automatic run_burst(input logic [31:0] a, input logic [2:0] s, input logic [1:0] b,
                             input logic [7:0] len, input logic [7:0] m0, input bit stall);
        @(negedge clk);
        chk("R2 ar_ready idle", 64'(ar_ready), 64'd1);
        ar_valid = 1'b1; ar_addr = a; ar_size = s; ar_burst = b; ar_len = len; r_ready = 1'b0;
        @(negedge clk);
        ar_valid = 1'b0;
        for (int n = 0; n <= int'(len); n++) begin
            logic [31:0] ba = exp_addr(a, s, b, n);
            logic [7:0]  m  = (n == 0 || b == 2'd0) ? m0 : exp_mask(ba, s);
            chk("R8 r_valid during burst", 64'(r_valid), 64'd1);
            chk("R2 ar_ready busy", 64'(ar_ready), 64'd0);
            chk("R3 R5 R6 R7 R11 r_data", r_data, exp_data(ba, m));
            chk("R10 mem_addr", 64'(mem_addr), 64'({ba[31:3], 3'b000}));
            chk("R8 r_last", 64'(r_last), 64'(n == int'(len)));
            if (stall && n == 1) begin
                @(negedge clk);
                chk("R9 stall data", r_data, exp_data(ba, m));
                chk("R9 stall addr", 64'(mem_addr), 64'({ba[31:3], 3'b000}));
                chk("R9 stall last", 64'(r_last), 64'(n == int'(len)));
            end
            r_ready = 1'b1;
            @(negedge clk);
            r_ready = 1'b0;
        end
        chk("R8 idle after last", 64'(r_valid), 64'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset r_valid", 64'(r_valid), 64'd0);
        chk("R1 reset ar_ready", 64'(ar_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle r_last", 64'(r_last), 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_burst(V_ADDR[v], V_SIZE[v], V_BURST[v], V_LEN[v], V_MASK0[v], v == 2 || v == 3);
            chk("R3 first mask model", 64'(exp_mask(V_ADDR[v], V_SIZE[v])), 64'(V_MASK0[v]));
        end

        // R4: full-width beat carries the whole word.
        run_burst(32'h48, 3'd3, 2'd1, 8'd0, 8'hFF, 1'b0);

        // R2: request held during a burst is ignored.
        @(negedge clk);
        ar_valid = 1'b1; ar_addr = 32'h0; ar_size = 3'd3; ar_burst = 2'd1; ar_len = 8'd1;
        @(negedge clk);
        ar_addr = 32'h40; ar_size = 3'd0; ar_len = 8'd7;
        chk("R2 busy ar_ready", 64'(ar_ready), 64'd0);
        chk("R2 beat0 data", r_data, 64'h0706050403020100);
        r_ready = 1'b1;
        @(negedge clk);
        ar_valid = 1'b0;
        chk("R2 beat1 data", r_data, 64'h0F0E0D0C0B0A0908);
        chk("R2 beat1 last", 64'(r_last), 64'd1);
        @(negedge clk);
        r_ready = 1'b0;
        chk("R2 not captured", 64'(r_valid), 64'd0);
        @(negedge clk);
        chk("R2 still idle", 64'(r_valid), 64'd0);

        // R1: reset in the middle of a burst.
        ar_valid = 1'b1; ar_addr = 32'h10; ar_size = 3'd2; ar_burst = 2'd1; ar_len = 8'd5;
        @(negedge clk);
        ar_valid = 1'b0;
        chk("R1 burst started", 64'(r_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset r_valid", 64'(r_valid), 64'd0);
        chk("R1 mid reset ar_ready", 64'(ar_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule